// File: doc/BRIEF.md
# Frame Pointer Address Generator

This block produces a data-memory address by adding an 8-bit offset register to a 16-bit base register. The offset is zero-extended and the sum is unsigned, truncated to 16 bits. Each access request says whether it is a read or a write. It may also ask for the offset to be stepped up or down by one.

A read uses the offset as it stands and then steps it (post-modify). A write steps the offset first and uses the stepped value (pre-modify). Stepping wraps inside the 8-bit offset, and no carry or borrow ever reaches the base register. Software can read and write both registers directly through a small register port. A direct write to the offset beats any step requested in the same cycle.

Top module: `fp_addr_gen`

## Requirements
- R1: After reset the base register reads 0000h and the offset register reads 00h.
- R2: During a read access (`acc_write`=0), `acc_addr` equals base plus the zero-extended current offset, modulo 2^16, in the same cycle.
- R3: A read access with `acc_mod`=01 (increment) or 10 (decrement) leaves the offset one higher or one lower after the next clock edge.
- R4: During a write access (`acc_write`=1), `acc_addr` equals base plus the stepped offset (offset+1 for 01, offset-1 for 10, unchanged otherwise), and the stepped value is stored at the next clock edge.
- R5: An offset step wraps within 8 bits (FFh+1 gives 00h, 00h-1 gives FFh), and the base register is unchanged by it.
- R6: `acc_mod` codes 00 and 11 leave the offset unchanged.
- R7: A register write with `reg_sel`=0 loads the base from `reg_wdata`. With `reg_sel`=1 it loads the offset from `reg_wdata[7:0]`. `reg_rdata` returns the base when `reg_sel`=0 and the zero-extended offset when `reg_sel`=1.
- R8: When an offset register write and an offset-modifying access fall in the same cycle, the offset takes the written value.
- R9: With `acc_valid` low and no offset write, the offset is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Direct register write strobe |
| reg_sel | input | 1 | Register select: 0 base, 1 offset |
| reg_wdata | input | 16 | Direct write data |
| reg_rdata | output | 16 | Read data of the selected register |
| acc_valid | input | 1 | Access request present |
| acc_write | input | 1 | 1 write access, 0 read access |
| acc_mod | input | 2 | Offset step: 00 none, 01 increment, 10 decrement, 11 none |
| acc_addr | output | 16 | Effective frame pointer address |

## Verification
The wrap cases are the hardest to reach from the ports. A pre-decrement at offset 00h must address base+FFh, and a post-increment at FFh must return to 00h. Each needs a specific offset loaded and a specific mode applied, and the base must then be shown to be untouched. The bench reaches them by sweeping every offset value against every step code and both access directions over several bases, including FFFFh, where the address sum also wraps. A final collision vector issues an offset write and a stepping access together to expose the priority rule.

// File: rtl/fp_addr_gen.sv
module fp_addr_gen #(
  parameter int BASE_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_sel,
  input  logic [BASE_W-1:0] reg_wdata,
  output logic [BASE_W-1:0] reg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_mod,
  output logic [BASE_W-1:0] acc_addr
);

  localparam int PAD_W = BASE_W - OFS_W;

  logic [BASE_W-1:0] base_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [OFS_W-1:0]  ofs_step;
  logic [OFS_W-1:0]  ofs_use;
  logic              step_on;
  logic              base_wr;
  logic              ofs_wr;

  assign base_wr = reg_wr_en && !reg_sel;
  assign ofs_wr  = reg_wr_en && reg_sel;

  always_comb begin
    unique case (acc_mod)
      2'b01:   ofs_step = ofs_q + 1'b1;
      2'b10:   ofs_step = ofs_q - 1'b1;
      default: ofs_step = ofs_q;
    endcase
  end

  assign step_on   = acc_valid && (acc_mod == 2'b01 || acc_mod == 2'b10);
  assign ofs_use   = acc_write ? ofs_step : ofs_q;
  assign acc_addr  = base_q + {{PAD_W{1'b0}}, ofs_use};
  assign reg_rdata = reg_sel ? {{PAD_W{1'b0}}, ofs_q} : base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_wr) begin
      base_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else if (ofs_wr) begin
      ofs_q <= reg_wdata[OFS_W-1:0];
    end else if (step_on) begin
      ofs_q <= ofs_step;
    end
  end

  AST_POST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !ofs_wr && acc_mod == 2'b01) |=> (ofs_q == $past(ofs_q) + 1'b1)); // R3

  AST_PRE_STEP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !ofs_wr && !base_wr) |=> (base_q + {{PAD_W{1'b0}}, ofs_q} == $past(acc_addr))); // R4

  AST_BASE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !base_wr) |=> $stable(base_q)); // R5

  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !ofs_wr && acc_mod == 2'b01 && ofs_q == {OFS_W{1'b1}}) |=> (ofs_q == '0)); // R5

  AST_NO_MOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !ofs_wr && (acc_mod == 2'b00 || acc_mod == 2'b11)) |=> $stable(ofs_q)); // R6

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_wr |=> (ofs_q == $past(reg_wdata[OFS_W-1:0]))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !ofs_wr) |=> $stable(ofs_q)); // R9

endmodule

// File: tb/fp_addr_gen_test.sv
`timescale 1ns/1ps
module fp_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_mod = 2'b00;
  logic [15:0] acc_addr;

  int checks = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  fp_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_mod(acc_mod), .acc_addr(acc_addr)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_reg(input string req, input logic sel, input logic [15:0] exp);
    reg_sel = sel;
    #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    logic [15:0] bases [5];
    bases[0] = 16'h0000; bases[1] = 16'h1234; bases[2] = 16'hFF80;
    bases[3] = 16'hFFFF; bases[4] = 16'h7F00;

    #12;
    rd_reg("R1 base", 1'b0, 16'h0000);
    rd_reg("R1 offset", 1'b1, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    wr_reg(1'b0, 16'hABCD);
    rd_reg("R7 base", 1'b0, 16'hABCD);
    wr_reg(1'b1, 16'hBE5A);
    rd_reg("R7 offset zero-extended", 1'b1, 16'h005A);

    for (int b = 0; b < 5; b++) begin
      wr_reg(1'b0, bases[b]);
      for (int o = 0; o < 256; o++) begin
        for (int w = 0; w < 2; w++) begin
          for (int m = 0; m < 4; m++) begin
            logic [7:0] ofs, nxt;
            logic [15:0] exp_addr;
            ofs = o[7:0];
            nxt = (m == 1) ? ofs + 8'd1 : (m == 2) ? ofs - 8'd1 : ofs;
            exp_addr = bases[b] + {8'h00, (w == 1) ? nxt : ofs};
            wr_reg(1'b1, {8'h00, ofs});
            acc_valid = 1'b1; acc_write = w[0]; acc_mod = m[1:0];
            #1;
            check(w == 1 ? "R4 pre-mod address" : "R2 post-mod address", acc_addr, exp_addr);
            @(negedge clk);
            acc_valid = 1'b0;
            rd_reg((m == 0 || m == 3) ? "R6 offset held" :
                   ((ofs == 8'hFF && m == 1) || (ofs == 8'h00 && m == 2)) ? "R5 offset wrap" :
                   (w == 1 ? "R4 offset stored" : "R3 offset stepped"), 1'b1, {8'h00, nxt});
            rd_reg("R5 base unchanged", 1'b0, bases[b]);
          end
        end
      end
    end

    wr_reg(1'b1, 16'h0040);
    repeat (3) @(negedge clk);
    rd_reg("R9 idle offset held", 1'b1, 16'h0040);

    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h0077;
    acc_valid = 1'b1; acc_write = 1'b1; acc_mod = 2'b01;
    @(negedge clk);
    reg_wr_en = 1'b0; acc_valid = 1'b0;
    rd_reg("R8 direct write wins", 1'b1, 16'h0077);

    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h0010;
    acc_valid = 1'b1; acc_write = 1'b0; acc_mod = 2'b10;
    @(negedge clk);
    reg_wr_en = 1'b0; acc_valid = 1'b0;
    rd_reg("R8 direct write wins on read", 1'b1, 16'h0010);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule